// File: doc/BRIEF.md
# Link Receive Word Buffer

This block holds incoming words from an inter-processor link receiver until a consumer, such as a DMA channel or a core read port, takes them. It has two word slots and returns them in arrival order. When both slots are occupied it lowers its ready line to the remote transmitter. The transmitter then holds its next word, so no word is ever lost. A consumer that asks for a word while the buffer is empty is stalled: its request is not acknowledged until a word has been stored.

Fill level is reported through a 2-bit status code with a gap in it: 0 means empty, 2 means one word and 3 means full. The code 1 never appears. A control write sets or clears an enable bit. Clearing the bit discards everything the buffer holds. While the bit is clear, the buffer refuses link words and stalls reads. Apart from this flush, the buffer only becomes empty when every stored word has been read and no new word has arrived in the meantime.

Top module: `lrx_buf`

## Requirements
- R1: After a synchronous reset the enable bit is clear, `stat` is 0, `lk_rdy` is low and a pending `rd_req` is not acknowledged.
- R2: `stat` encodes the number of held words as 0 (none), 2 (one) or 3 (two), and never takes the value 1.
- R3: While two words are held, `lk_rdy` is low and a word offered on `lk_valid` is not stored.
- R4: Words are delivered on `rd_data`, qualified by `rd_ack`, in exactly the order in which they were accepted.
- R5: A read request while the buffer is empty is not acknowledged. This holds even when a word is accepted in the same cycle; the read completes in a later cycle.
- R6: With one word held, an accepted write and an acknowledged read in the same cycle both take effect, and `stat` stays 2.
- R7: After a read from a full buffer, `lk_rdy` is high in the next cycle.
- R8: A control write with `ctl_en`=0 discards all held words: in the next cycle `stat` is 0 and `lk_rdy` is low. Re-enabling starts from an empty buffer.
- R9: While the enable bit is clear, `lk_rdy` is low, offered words are refused and read requests are not acknowledged.
- R10: With the buffer full, a read and an offered write in the same cycle complete the read and refuse the write, leaving `stat` at 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Strobe that writes the enable bit |
| ctl_en | input | 1 | New value of the enable bit |
| lk_valid | input | 1 | Link receiver offers a word |
| lk_data | input | DATA_W | Offered word |
| lk_rdy | output | 1 | Ready handshake to the remote transmitter |
| rd_req | input | 1 | Consumer requests a word |
| rd_ack | output | 1 | Read completes this cycle |
| rd_data | output | DATA_W | Oldest held word |
| stat | output | 2 | Fill status code (0, 2 or 3) |

## Verification
A link write and a consumer read can fall in the same cycle. They interact differently at each fill level. On an empty buffer the read must still stall. On a one-word buffer both must take effect. On a full buffer the read completes but the write is refused. Some cycles also carry a flush, which must override both.

The bench drives this collision in a sweep. It first brings the buffer to each fill level. It then applies every combination of offered write, read request and enable-bit write for a single cycle. Afterwards it drains the buffer, and the drain shows whether any word was lost, duplicated or reordered. A queue model in the bench predicts the ready, acknowledge, data and status values for every cycle.

// File: rtl/lrx_pkg.sv
package lrx_pkg;

    localparam int unsigned LRX_SLOTS = 2;
    localparam int unsigned LRX_PW    = $clog2(LRX_SLOTS);
    localparam int unsigned LRX_LW    = $clog2(LRX_SLOTS + 1);

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_ONE   = 2'd2,
        ST_FULL  = 2'd3
    } lrx_stat_e;

    typedef struct packed {
        logic wr;
        logic rd;
        logic flush;
    } lrx_ops_t;

    function automatic lrx_stat_e lrx_encode(input logic [LRX_LW-1:0] lvl);
        case (lvl)
            LRX_LW'(0): return ST_EMPTY;
            LRX_LW'(1): return ST_ONE;
            default:    return ST_FULL;
        endcase
    endfunction

endpackage

// File: rtl/lrx_ctl.sv
module lrx_ctl
    import lrx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic              ctl_en,
    input  logic              lk_valid,
    input  logic              rd_req,
    output logic              rdy,
    output lrx_ops_t          ops,
    output logic [LRX_LW-1:0] lvl,
    output logic [LRX_PW-1:0] wptr,
    output logic [LRX_PW-1:0] rptr
);

    logic en_q;
    logic full;
    logic empty;

    assign full  = (lvl == LRX_LW'(LRX_SLOTS));
    assign empty = (lvl == '0);
    assign rdy   = en_q && !full;

    assign ops.wr    = lk_valid && rdy;
    assign ops.rd    = rd_req && en_q && !empty;
    assign ops.flush = ctl_wr && !ctl_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= 1'b0;
            lvl  <= '0;
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (ctl_wr)
                en_q <= ctl_en;
            if (ops.flush) begin
                lvl  <= '0;
                wptr <= '0;
                rptr <= '0;
            end else begin
                if (ops.wr)
                    wptr <= wptr + LRX_PW'(1);
                if (ops.rd)
                    rptr <= rptr + LRX_PW'(1);
                lvl <= lvl + LRX_LW'(ops.wr) - LRX_LW'(ops.rd);
            end
        end
    end

endmodule

// File: rtl/lrx_store.sv
module lrx_store
    import lrx_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [LRX_PW-1:0] wptr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LRX_PW-1:0] rptr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] slot [LRX_SLOTS];

    for (genvar g = 0; g < LRX_SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && (wptr == LRX_PW'(g)))
                slot[g] <= wdata;
        end
    end

    assign rdata = slot[rptr];

endmodule

// File: rtl/lrx_buf.sv
module lrx_buf
    import lrx_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic              ctl_en,
    input  logic              lk_valid,
    input  logic [DATA_W-1:0] lk_data,
    output logic              lk_rdy,
    input  logic              rd_req,
    output logic              rd_ack,
    output logic [DATA_W-1:0] rd_data,
    output logic [1:0]        stat
);

    lrx_ops_t          ops;
    logic [LRX_LW-1:0] lvl;
    logic [LRX_PW-1:0] wptr;
    logic [LRX_PW-1:0] rptr;

    lrx_ctl u_ctl (
        .clk      (clk),
        .rst      (rst),
        .ctl_wr   (ctl_wr),
        .ctl_en   (ctl_en),
        .lk_valid (lk_valid),
        .rd_req   (rd_req),
        .rdy      (lk_rdy),
        .ops      (ops),
        .lvl      (lvl),
        .wptr     (wptr),
        .rptr     (rptr)
    );

    lrx_store #(.DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .wr_en (ops.wr && !ops.flush),
        .wptr  (wptr),
        .wdata (lk_data),
        .rptr  (rptr),
        .rdata (rd_data)
    );

    assign rd_ack = ops.rd;
    assign stat   = lrx_encode(lvl);

endmodule

// File: rtl/lrx_chk.sv
module lrx_chk (
    input logic       clk,
    input logic       rst,
    input logic       ctl_wr,
    input logic       ctl_en,
    input logic       lk_valid,
    input logic       lk_rdy,
    input logic       rd_ack,
    input logic [1:0] stat
);

    p_no_code1_r2: assert property (@(posedge clk) disable iff (rst)
        stat != 2'd1);

    p_full_stalls_r3: assert property (@(posedge clk) disable iff (rst)
        (stat == 2'd3) |-> !lk_rdy);

    p_empty_no_ack_r5: assert property (@(posedge clk) disable iff (rst)
        (stat == 2'd0) |-> !rd_ack);

    p_pass_through_r6: assert property (@(posedge clk) disable iff (rst)
        (stat == 2'd2 && lk_valid && lk_rdy && rd_ack && !ctl_wr) |=> (stat == 2'd2));

    p_rdy_returns_r7: assert property (@(posedge clk) disable iff (rst)
        (stat == 2'd3 && rd_ack && !ctl_wr) |=> lk_rdy);

    p_flush_empties_r8: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && !ctl_en) |=> (stat == 2'd0 && !lk_rdy));

    p_full_read_r10: assert property (@(posedge clk) disable iff (rst)
        (stat == 2'd3 && rd_ack && !ctl_wr) |=> (stat == 2'd2));

endmodule

bind lrx_buf lrx_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ctl_wr   (ctl_wr),
    .ctl_en   (ctl_en),
    .lk_valid (lk_valid),
    .lk_rdy   (lk_rdy),
    .rd_ack   (rd_ack),
    .stat     (stat)
);

// File: tb/sim_lrx_buf.sv
module sim_lrx_buf;

    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          ctl_wr;
    logic          ctl_en;
    logic          lk_valid;
    logic [DW-1:0] lk_data;
    logic          lk_rdy;
    logic          rd_req;
    logic          rd_ack;
    logic [DW-1:0] rd_data;
    logic [1:0]    stat;

    always #4 clk = ~clk;

    lrx_buf #(.DATA_W(DW)) u0 (
        .clk      (clk),
        .rst      (rst),
        .ctl_wr   (ctl_wr),
        .ctl_en   (ctl_en),
        .lk_valid (lk_valid),
        .lk_data  (lk_data),
        .lk_rdy   (lk_rdy),
        .rd_req   (rd_req),
        .rd_ack   (rd_ack),
        .rd_data  (rd_data),
        .stat     (stat)
    );

    int            vectors = 0;
    int            bad     = 0;
    bit            done    = 0;
    logic [DW-1:0] mq[$];
    bit            men     = 0;
    int            seq     = 0;

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        vectors++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] enc(input int n);
        return (n == 0) ? 2'd0 : (n == 1) ? 2'd2 : 2'd3;
    endfunction

    task automatic step(input bit v, input bit r, input bit cw, input bit ce, input string stag);
        bit            mrdy;
        bit            mack;
        logic [DW-1:0] d;
        d = 32'h5A00_0000 ^ (DW'(seq) * 32'h0001_0203);
        seq++;
        lk_valid = v; lk_data = d; rd_req = r; ctl_wr = cw; ctl_en = ce;
        #2;
        mrdy = men && (mq.size() < 2);
        mack = r && men && (mq.size() > 0);
        chk(lk_rdy === mrdy, !men ? "R9" : (mq.size() == 2 ? "R3" : "R7"), DW'(lk_rdy), DW'(mrdy));
        chk(rd_ack === mack, !men ? "R9" : (mq.size() == 0 ? "R5" : "R4"), DW'(rd_ack), DW'(mack));
        if (mack)
            chk(rd_data === mq[0], "R4", rd_data, mq[0]);
        @(posedge clk);
        if (cw && !ce) begin
            mq.delete();
            men = 0;
        end else begin
            if (mack) void'(mq.pop_front());
            if (v && mrdy) mq.push_back(d);
            if (cw) men = ce;
        end
        #1;
        lk_valid = 0; rd_req = 0; ctl_wr = 0; ctl_en = 0;
        chk(stat === enc(mq.size()), stag, DW'(stat), DW'(enc(mq.size())));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            bad++;
            $display("FAIL R5 watchdog act=hung exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
            $finish;
        end
    end

    initial begin
        rst = 1; ctl_wr = 0; ctl_en = 0; lk_valid = 0; lk_data = '0; rd_req = 0;
        repeat (3) @(posedge clk);
        #1;
        rd_req = 1;
        #2;
        chk(stat === 2'd0, "R1", DW'(stat), 0);
        chk(lk_rdy === 1'b0, "R1", DW'(lk_rdy), 0);
        chk(rd_ack === 1'b0, "R1", DW'(rd_ack), 0);
        rst = 0;
        @(posedge clk);
        #1;
        rd_req = 0;
        chk(stat === 2'd0, "R1", DW'(stat), 0);
        chk(lk_rdy === 1'b0, "R1", DW'(lk_rdy), 0);

        // Sweep: fill level x write x read x control action
        for (int fill = 0; fill <= 2; fill++)
            for (int v = 0; v <= 1; v++)
                for (int r = 0; r <= 1; r++)
                    for (int c = 0; c <= 2; c++) begin
                        string tag;
                        step(0, 0, 1, 0, "R8");
                        step(0, 0, 1, 1, "R8");
                        for (int k = 0; k < fill; k++)
                            step(1, 0, 0, 0, "R2");
                        if (c == 2)                         tag = "R8";
                        else if (fill == 1 && v == 1 && r == 1) tag = "R6";
                        else if (fill == 2 && r == 1)       tag = "R10";
                        else                                tag = "R2";
                        step(bit'(v), bit'(r), c != 0, c == 1, tag);
                        while (mq.size() > 0)
                            step(0, 1, 0, 0, "R4");
                        step(0, 1, 0, 0, "R5");
                    end

        // Disabled buffer refuses words and stalls reads
        step(0, 0, 1, 0, "R8");
        step(1, 1, 0, 0, "R9");
        step(1, 0, 0, 0, "R9");
        step(0, 0, 1, 1, "R9");
        step(0, 1, 0, 0, "R5");

        // Streaming: transmitter keeps sending while consumer drains
        step(1, 0, 0, 0, "R2");
        step(1, 0, 0, 0, "R2");
        for (int k = 0; k < 8; k++)
            step(1, 1, 0, 0, "R6");
        step(1, 0, 0, 0, "R2");
        step(1, 0, 0, 0, "R3");
        while (mq.size() > 0)
            step(0, 1, 0, 0, "R4");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
        $finish;
    end

endmodule